// File: doc/BRIEF.md
# SDIO FIFO Window Length Controller

This block sits behind the command decoder of an SDIO slave and carries the data phase of an incrementing multi-byte command aimed at the FIFO window of function 1. The command fields arrive as one pulse. The block derives two lengths from them. The first is the requested length, which is encoded as the distance of the start address below the window's top boundary 0x1F800. The second is the transfer length, which comes from the block or byte count. The block then runs exactly the transfer length of byte beats on the host-side stream.

Slave-to-host ("up") beats take bytes from the transmit queue until the requested length is used up. After that they carry zero bytes. Host-to-slave ("down") beats push bytes into the receive queue until the requested length is used up. After that the bytes are accepted and dropped. When the last beat is done, a one-cycle `done` reports how many bytes crossed the queues.

All four data interfaces are valid/ready. A byte moves on a cycle where both are high.
- Back-pressure rules for the up stream: `up_valid` never waits on `up_ready`. While the block is still serving queue bytes, `up_valid` follows `txq_valid`.
- Back-pressure rules for the down stream: `dn_ready` never waits on `dn_valid`. While the block is still serving queue bytes, `dn_ready` follows `rxq_ready`.
- In the pad or discard phase, the queue side is idle. `up_valid` and `dn_ready` are then held high by the block itself.

Top module: `sdio_fifo_window`

## Requirements
- R1: Queue bytes are used only when `cmd_func` is 1, `cmd_op_inc` is 1, and `cmd_addr` lies in 0x090..0x1F7FF. Any other command gets a requested length of 0: its beats still run, but every up byte is 0x00, every down byte is dropped, and neither queue sees a handshake.
- R2: The requested length is 0x1F800 minus `cmd_addr`. For example, 0x1F7FF gives 1 and 0x090 gives 0x1F770.
- R3: The number of stream beats equals the transfer length. With `cmd_block`=1 this is `cmd_count`×512. With `cmd_block`=0 it is `cmd_count`, where a count of 0 means 512.
- R4: On an up transfer (`cmd_write`=0), the first min(requested, transfer) beats carry `txq_data` in queue order, with exactly one queue pop per beat.
- R5: Up beats past the requested length carry 0x00 and pop nothing.
- R6: On a down transfer (`cmd_write`=1), the first min(requested, transfer) beats are pushed to the receive queue in order, with `rxq_data` equal to `dn_data`.
- R7: Down beats past the requested length push nothing. In that phase `dn_ready` is high whatever `rxq_ready` is.
- R8: In the queue phase, `up_valid` is low while `txq_valid` is low, and `dn_ready` is low while `rxq_ready` is low. The block stalls and neither inserts filler nor drops data.
- R9: `done` is high for one cycle, in the cycle after the final beat. `done_bytes` then equals the number of queue bytes moved. A block-mode count of 0 gives no beats and a `done` in the cycle after the command, with `done_bytes`=0.
- R10: `cmd_valid` is ignored while `busy` is high.
- R11: A block-mode command of 2 blocks at 0x1F3F9, followed by a byte-mode command of 8 at 0x1F7F9, delivers 1031 contiguous transmit-queue bytes and then one 0x00.
- R12: After reset, `busy`, `done`, `up_valid`, `dn_ready`, `txq_ready` and `rxq_valid` are low, and `done_bytes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_func | input | 3 | Function number |
| cmd_op_inc | input | 1 | Incrementing-address flag |
| cmd_write | input | 1 | 1 = host-to-slave, 0 = slave-to-host |
| cmd_block | input | 1 | 1 = block mode, 0 = byte mode |
| cmd_addr | input | 17 | Start register address |
| cmd_count | input | 9 | Block or byte count field |
| busy | output | 1 | Transfer in progress |
| up_valid | output | 1 | Slave-to-host byte valid |
| up_ready | input | 1 | Host side accepts byte |
| up_data | output | 8 | Slave-to-host byte |
| dn_valid | input | 1 | Host-to-slave byte valid |
| dn_ready | output | 1 | Block accepts byte |
| dn_data | input | 8 | Host-to-slave byte |
| txq_valid | input | 1 | Transmit queue has a byte |
| txq_ready | output | 1 | Pop transmit queue |
| txq_data | input | 8 | Transmit queue head |
| rxq_valid | output | 1 | Push to receive queue |
| rxq_ready | input | 1 | Receive queue has space |
| rxq_data | output | 8 | Byte for receive queue |
| done | output | 1 | End-of-transfer pulse |
| done_bytes | output | 18 | Queue bytes moved by the finished transfer |

## Verification
A wrong transfer-length counter shows as a beat count that differs from the count field. The `done` pulse then comes early or late, so the error is visible by the end of that same command. A wrong requested-length counter moves the boundary between real and zero bytes on the up stream, or between pushed and dropped bytes on the down stream. This shows up in the first beat past the boundary, and in `done_bytes`. A stuck direction or phase flag shows at once as a handshake on the wrong queue. The back-to-back case exposes any state left over from one command into the next: the transmit sequence would break at byte 1024.

// File: rtl/sdfw_pkg.sv
package sdfw_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;

  function automatic int unsigned min_len(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/sdfw_len_calc.sv
module sdfw_len_calc #(
  parameter int ADDR_W    = 17,
  parameter int CNT_W     = 9,
  parameter int LEN_W     = 18,
  parameter int BLK_SIZE  = 512,
  parameter int WIN_LO    = 'h00090,
  parameter int WIN_TOP   = 'h1F800,
  parameter int FUNC_ID   = 1
) (
  input  logic [2:0]        func,
  input  logic              op_inc,
  input  logic              blk_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  output logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  xfer_len
);
  logic [LEN_W-1:0] addr_x;
  logic [LEN_W-1:0] cnt_x;
  logic             in_win;
  logic             hit;

  always_comb begin
    addr_x = LEN_W'(addr);
    cnt_x  = LEN_W'(count);
    in_win = (addr_x >= LEN_W'(WIN_LO)) && (addr_x < LEN_W'(WIN_TOP));
    hit    = (func == 3'(FUNC_ID)) && op_inc && in_win;
    req_len = hit ? (LEN_W'(WIN_TOP) - addr_x) : '0;
    if (blk_mode)
      xfer_len = cnt_x * LEN_W'(BLK_SIZE);
    else if (count == '0)
      xfer_len = LEN_W'(1 << CNT_W);
    else
      xfer_len = cnt_x;
  end
endmodule

// File: rtl/sdfw_seq.sv
module sdfw_seq
  import sdfw_pkg::*;
#(
  parameter int LEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             beat,
  output logic             busy,
  output dir_e             dir,
  output logic             in_fifo,
  output logic             done,
  output logic [LEN_W-1:0] done_bytes
);
  logic [LEN_W-1:0] rem_xfer;
  logic [LEN_W-1:0] rem_req;
  logic [LEN_W-1:0] moved;

  assign busy    = (rem_xfer != '0);
  assign in_fifo = (rem_req != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_xfer   <= '0;
      rem_req    <= '0;
      moved      <= '0;
      dir        <= DIR_UP;
      done       <= 1'b0;
      done_bytes <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        dir      <= start_wr ? DIR_DN : DIR_UP;
        rem_xfer <= xfer_len;
        rem_req  <= req_len;
        moved    <= '0;
        if (xfer_len == '0) begin
          done       <= 1'b1;
          done_bytes <= '0;
        end
      end else if (beat) begin
        rem_xfer <= rem_xfer - 1'b1;
        if (in_fifo) begin
          rem_req <= rem_req - 1'b1;
          moved   <= moved + 1'b1;
        end
        if (rem_xfer == LEN_W'(1)) begin
          done       <= 1'b1;
          done_bytes <= moved + LEN_W'(in_fifo);
          rem_req    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sdfw_route.sv
module sdfw_route
  import sdfw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busy,
  input  dir_e              dir,
  input  logic              in_fifo,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [DATA_W-1:0] up_data,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic [DATA_W-1:0] dn_data,
  input  logic              txq_valid,
  output logic              txq_ready,
  input  logic [DATA_W-1:0] txq_data,
  output logic              rxq_valid,
  input  logic              rxq_ready,
  output logic [DATA_W-1:0] rxq_data,
  output logic              beat
);
  logic up_act;
  logic dn_act;

  always_comb begin
    up_act    = busy && (dir == DIR_UP);
    dn_act    = busy && (dir == DIR_DN);
    up_valid  = up_act && (in_fifo ? txq_valid : 1'b1);
    up_data   = (up_act && in_fifo) ? txq_data : '0;
    txq_ready = up_act && in_fifo && up_ready;
    dn_ready  = dn_act && (in_fifo ? rxq_ready : 1'b1);
    rxq_valid = dn_act && in_fifo && dn_valid;
    rxq_data  = dn_data;
    beat      = (up_valid && up_ready) || (dn_valid && dn_ready);
  end
endmodule

// File: rtl/sdio_fifo_window.sv
module sdio_fifo_window
  import sdfw_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int CNT_W    = 9,
  parameter int DATA_W   = 8,
  parameter int BLK_SIZE = 512,
  parameter int WIN_LO   = 'h00090,
  parameter int WIN_TOP  = 'h1F800,
  parameter int FUNC_ID  = 1,
  localparam int LEN_W   = $clog2(((1 << CNT_W) - 1) * BLK_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_func,
  input  logic              cmd_op_inc,
  input  logic              cmd_write,
  input  logic              cmd_block,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              busy,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [DATA_W-1:0] up_data,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic [DATA_W-1:0] dn_data,
  input  logic              txq_valid,
  output logic              txq_ready,
  input  logic [DATA_W-1:0] txq_data,
  output logic              rxq_valid,
  input  logic              rxq_ready,
  output logic [DATA_W-1:0] rxq_data,
  output logic              done,
  output logic [LEN_W-1:0]  done_bytes
);
  logic [LEN_W-1:0] req_len;
  logic [LEN_W-1:0] xfer_len;
  logic             beat;
  logic             in_fifo;
  dir_e             dir;

  sdfw_len_calc #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .BLK_SIZE(BLK_SIZE),
    .WIN_LO(WIN_LO), .WIN_TOP(WIN_TOP), .FUNC_ID(FUNC_ID)
  ) u_len (
    .func(cmd_func), .op_inc(cmd_op_inc), .blk_mode(cmd_block),
    .addr(cmd_addr), .count(cmd_count),
    .req_len(req_len), .xfer_len(xfer_len)
  );

  sdfw_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_valid), .start_wr(cmd_write),
    .req_len(req_len), .xfer_len(xfer_len), .beat(beat),
    .busy(busy), .dir(dir), .in_fifo(in_fifo),
    .done(done), .done_bytes(done_bytes)
  );

  sdfw_route #(.DATA_W(DATA_W)) u_route (
    .busy(busy), .dir(dir), .in_fifo(in_fifo),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .txq_valid(txq_valid), .txq_ready(txq_ready), .txq_data(txq_data),
    .rxq_valid(rxq_valid), .rxq_ready(rxq_ready), .rxq_data(rxq_data),
    .beat(beat)
  );
endmodule

// File: rtl/sdfw_chk.sv
module sdfw_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              up_valid,
  input logic              up_ready,
  input logic [DATA_W-1:0] up_data,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              txq_valid,
  input logic              txq_ready,
  input logic [DATA_W-1:0] txq_data,
  input logic              rxq_valid,
  input logic              rxq_ready,
  input logic              done
);
  // R4
  pop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_valid && txq_ready) |-> (up_valid && up_ready && up_data == txq_data));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && !txq_ready) |-> (up_data == '0));

  // R6
  push_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_valid && rxq_ready) |-> (dn_valid && dn_ready));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!up_valid && !dn_ready && !txq_ready && !rxq_valid));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind sdio_fifo_window sdfw_chk #(.DATA_W(DATA_W)) u_sdfw_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
  .dn_valid(dn_valid), .dn_ready(dn_ready),
  .txq_valid(txq_valid), .txq_ready(txq_ready), .txq_data(txq_data),
  .rxq_valid(rxq_valid), .rxq_ready(rxq_ready), .done(done)
);

// File: tb/test_sdio_fifo_window.sv
module test_sdio_fifo_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_func = '0;
  logic        cmd_op_inc = 1'b0;
  logic        cmd_write = 1'b0;
  logic        cmd_block = 1'b0;
  logic [16:0] cmd_addr = '0;
  logic [8:0]  cmd_count = '0;
  logic        busy;
  logic        up_valid;
  logic        up_ready = 1'b0;
  logic [7:0]  up_data;
  logic        dn_valid = 1'b0;
  logic        dn_ready;
  logic [7:0]  dn_data = '0;
  logic        txq_valid = 1'b0;
  logic        txq_ready;
  logic [7:0]  txq_data = '0;
  logic        rxq_valid;
  logic        rxq_ready = 1'b0;
  logic [7:0]  rxq_data;
  logic        done;
  logic [17:0] done_bytes;

  int n_chk = 0;
  int n_fail = 0;
  int tx_ptr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdio_fifo_window i_sdio_fifo_window (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_op_inc(cmd_op_inc), .cmd_write(cmd_write), .cmd_block(cmd_block),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count), .busy(busy),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .txq_valid(txq_valid), .txq_ready(txq_ready), .txq_data(txq_data),
    .rxq_valid(rxq_valid), .rxq_ready(rxq_ready), .rxq_data(rxq_data),
    .done(done), .done_bytes(done_bytes)
  );

  function automatic logic [7:0] tx_pat(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] wr_pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // One command, then the beats until done; every result checked here.
  task automatic run_xfer(input bit wr, input bit blk, input logic [2:0] fn,
                          input bit op, input int addr, input int cnt,
                          input bit stall, input bit inject,
                          input int exp_req, input int exp_xfer, input string rq);
    int m;
    int beats = 0;
    int fifo_n = 0;
    int data_err = 0;
    int stall_err = 0;
    int ready_err = 0;
    int last_beat = -1;
    int done_at = -1;
    int done_cnt = 0;
    int got_bytes = 0;
    int tx_start;
    m = (exp_req < exp_xfer) ? exp_req : exp_xfer;
    tx_start = tx_ptr;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = fn; cmd_op_inc = op; cmd_write = wr;
    cmd_block = blk; cmd_addr = 17'(addr); cmd_count = 9'(cnt);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      cmd_valid = (inject && cyc == 3);
      if (inject && cyc == 3) begin
        cmd_write = 1'b1; cmd_block = 1'b1; cmd_addr = 17'h00090; cmd_count = 9'd1;
        cmd_func = 3'd1; cmd_op_inc = 1'b1;
      end
      up_ready  = stall ? (cyc % 2 == 0) : 1'b1;
      txq_valid = stall ? (cyc % 3 != 1) : 1'b1;
      txq_data  = tx_pat(tx_ptr);
      dn_valid  = stall ? (cyc % 4 != 2) : 1'b1;
      dn_data   = wr_pat(beats);
      rxq_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (done) begin
        done_cnt++;
        if (done_at < 0) begin
          done_at = cyc;
          got_bytes = int'(done_bytes);
        end
      end
      if (!wr) begin
        if (fifo_n < m && beats < exp_xfer && !txq_valid && up_valid) stall_err++;
        if (up_valid && up_ready) begin
          if (beats < m) begin
            if (up_data != tx_pat(tx_start + beats)) data_err++;
          end else if (up_data != 8'h00) data_err++;
          if (txq_ready && txq_valid) begin fifo_n++; tx_ptr++; end
          beats++; last_beat = cyc;
        end
      end else begin
        if (fifo_n < m && !rxq_ready && dn_ready) stall_err++;
        if (fifo_n >= m && beats < exp_xfer && !dn_ready) ready_err++;
        if (dn_valid && dn_ready) begin
          if (rxq_valid && rxq_ready) begin
            if (rxq_data != wr_pat(fifo_n)) data_err++;
            fifo_n++;
          end
          beats++; last_beat = cyc;
        end
      end
      if (done_at >= 0 && cyc >= done_at + 2) break;
    end
    chk(beats == exp_xfer, "R3", "beat count", beats, exp_xfer);
    chk(fifo_n == m, wr ? "R6" : "R4", "queue bytes", fifo_n, m);
    chk(data_err == 0, wr ? "R6" : "R5", "data mismatches", data_err, 0);
    chk(stall_err == 0, "R8", "beats while queue stalled", stall_err, 0);
    if (wr) chk(ready_err == 0, "R7", "dn_ready low in discard phase", ready_err, 0);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(done_at == last_beat + 1, "R9", "done cycle", done_at, last_beat + 1);
    chk(got_bytes == m, rq, "done_bytes", got_bytes, m);
    chk(busy == 1'b0, "R10", "busy after done", busy, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !done && !up_valid && !dn_ready && !txq_ready && !rxq_valid,
        "R12", "idle outputs after reset", 1, 0);
    chk(done_bytes == '0, "R12", "done_bytes after reset", done_bytes, 0);
  endtask

  // R2 / R5: short requested length, padding after it
  task automatic t_read_pad();
    run_xfer(0, 0, 3'd1, 1, 'h1F7FC, 10, 0, 0, 4, 10, "R2");
    run_xfer(0, 0, 3'd1, 1, 'h1F7FF, 2, 1, 0, 1, 2, "R2");
  endtask

  // R4 / R8: block mode with stalls on both sides
  task automatic t_read_block_stall();
    run_xfer(0, 1, 3'd1, 1, 'h1F700, 1, 1, 0, 256, 512, "R4");
  endtask

  // R6 / R7: writes shorter and longer than the requested length
  task automatic t_write();
    run_xfer(1, 0, 3'd1, 1, 'h1F7F0, 8, 1, 0, 16, 8, "R6");
    run_xfer(1, 0, 3'd1, 1, 'h1F7FA, 20, 1, 0, 6, 20, "R7");
  endtask

  // R3: byte count 0 means 512
  task automatic t_byte_zero();
    run_xfer(1, 0, 3'd1, 1, 'h1F600, 0, 0, 0, 512, 512, "R3");
  endtask

  // R1: window edges, wrong function, non-incrementing
  task automatic t_window();
    run_xfer(0, 0, 3'd1, 1, 'h00090, 3, 0, 0, 'h1F770, 3, "R1");
    run_xfer(0, 0, 3'd1, 1, 'h0008F, 3, 0, 0, 0, 3, "R1");
    run_xfer(1, 0, 3'd2, 1, 'h1F7F0, 4, 0, 0, 0, 4, "R1");
    run_xfer(1, 0, 3'd1, 0, 'h1F7F0, 4, 0, 0, 0, 4, "R1");
  endtask

  // R9: block count 0
  task automatic t_zero_block();
    run_xfer(0, 1, 3'd1, 1, 'h1F700, 0, 0, 0, 256, 0, "R9");
  endtask

  // R10: command while busy
  task automatic t_ignore_busy();
    run_xfer(0, 0, 3'd1, 1, 'h1F7F0, 16, 0, 1, 16, 16, "R10");
  endtask

  // R11: block then byte back to back
  task automatic t_back_to_back();
    int start;
    start = tx_ptr;
    run_xfer(0, 1, 3'd1, 1, 'h1F3F9, 2, 0, 0, 1031, 1024, "R11");
    run_xfer(0, 0, 3'd1, 1, 'h1F7F9, 8, 0, 0, 7, 8, "R11");
    chk(tx_ptr - start == 1031, "R11", "contiguous bytes popped", tx_ptr - start, 1031);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read_pad();
    t_read_block_stall();
    t_write();
    t_byte_zero();
    t_window();
    t_zero_block();
    t_ignore_busy();
    t_back_to_back();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule